// File: doc/BRIEF.md
# Synchronous Serial Shift Interface

The block is an 8-bit clocked serial transceiver sitting behind a small register port on the processor side. It exchanges one byte per transfer with a peer over three wires: a shift clock, a data output and a data input. The shift clock either comes from the block itself, which derives it from the system clock with a selectable divider (master), or from the peer (slave). In slave mode the external clock and data are brought into the system clock domain through a two-flop synchronizer and their edges are detected there.

Software first touches the data register, by writing the byte to send or by reading the last byte received. That access arms the engine. Software then writes the trigger bit. Bits travel least-significant first. Outgoing data always changes on the falling shift-clock edge, and a control bit chooses which edge captures incoming data. After the eighth bit the received byte sits in the data register and a completion flag is set. That flag, gated by a mask bit, drives the interrupt output.

Register map, by `reg_addr`: 0 is the data register. 1 is control: bits [1:0] select the clock, bit 2 selects the sampling edge and bit 3 is the trigger. 2 is interrupt: bit 0 is the mask and bit 1 is the completion flag. Any other address reads 0.

Top module: `sync_shift_if`

## Requirements
- R1: After reset the control register reads 0x00 (external clock, rising-edge sampling), the interrupt register reads 0x00, `irq` is low, `sclk_out` is high and `sdo` is high.
- R2: With clock select 11, 10 or 01 the block is master. Each low and high phase of `sclk_out` lasts 1, 2 or 4 system clock cycles respectively. A transfer produces exactly 8 low pulses, and `sclk_out` idles high between transfers.
- R3: The transmitted byte leaves on `sdo` least-significant bit first. In master mode `sdo` changes only in the cycle in which `sclk_out` falls.
- R4: With control bit 2 at 0, input data is captured on rising shift-clock edges. With it at 1, input data is captured on falling edges. The first bit captured ends up in bit 0 of the data register, and the whole received byte can be read there once the transfer completes.
- R5: Clock select 00 is slave mode. Shifting follows the synchronized `sclk_in`. External clock edges that arrive before an accepted trigger shift nothing and leave the data register unchanged.
- R6: The trigger (control bit 3) always reads back as 0. A trigger issued with no data-register access since reset or since the last accepted trigger starts nothing.
- R7: While a transfer runs, further triggers and writes to the data register are ignored. The byte sent and the byte received are those of the running transfer.
- R8: A read of the data register arms the engine just as a write does. Each accepted trigger uses up the arming, so a second trigger without a new access starts nothing.
- R9: Completion sets the flag (interrupt bit 1). `irq` equals flag AND mask (interrupt bit 0). Writing 1 to bit 1 clears the flag. The mask resets to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_rd | input | 1 | Register read strobe, one cycle per read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| sclk_in | input | 1 | External shift clock (slave mode) |
| sdi | input | 1 | Serial data input |
| sclk_out | output | 1 | Generated shift clock (master mode), idles high |
| sdo | output | 1 | Serial data output |
| irq | output | 1 | Completion interrupt, flag AND mask |

## Verification
A wrong bit counter or a stuck run state shows up directly on `sclk_out`. Within one transfer it produces a ninth pulse, a missing pulse or a clock that never returns high, and in slave mode it shows as a flag that never rises. Errors in the shift register or in edge selection appear as a byte that is shifted by one or reversed. That byte shows in the captured `sdo` stream and in the data register read right after the flag. A lost or leaked arming state shows within a few tens of cycles: either a trigger that produces clock pulses when it should not, or one that produces none when it should.

// File: rtl/ssi_pkg.sv
package ssi_pkg;

  // Shift clock source; the three internal choices make the block master.
  typedef enum logic [1:0] {
    CS_EXT  = 2'b00,
    CS_DIV4 = 2'b01,
    CS_DIV2 = 2'b10,
    CS_DIV1 = 2'b11
  } clk_src_e;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_IRQ  = 2'd2;

  // Control and interrupt field positions
  localparam int CTRL_SAMPLE_FALL = 2;
  localparam int CTRL_TRIG        = 3;
  localparam int IRQ_MASK_BIT     = 0;
  localparam int IRQ_FLAG_BIT     = 1;

  // Longest half period of the generated clock, in system clock cycles
  localparam int MAX_HALF = 4;

endpackage

// File: rtl/ssi_sync.sv
module ssi_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q <= {stg_q[STAGES-2:0], d};
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/ssi_clkgen.sv
module ssi_clkgen
  import ssi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  clk_src_e src,
  input  logic     run,
  input  logic     ext_sclk_s,
  output logic     master,
  output logic     sclk_out,
  output logic     fall_ev,
  output logic     rise_ev
);

  localparam int CNT_W = $clog2(MAX_HALF);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] half_m1;
  logic             sclk_q, sclk_n;
  logic             ext_prev_q;
  logic             tick;

  assign master = (src != CS_EXT);

  always_comb begin
    unique case (src)
      CS_DIV1: half_m1 = CNT_W'(0);
      CS_DIV2: half_m1 = CNT_W'(1);
      default: half_m1 = CNT_W'(MAX_HALF - 1);
    endcase
  end

  assign tick = run && master && (cnt_q == half_m1);

  always_comb begin
    cnt_n  = cnt_q;
    sclk_n = sclk_q;
    if (!run || !master) begin
      cnt_n  = '0;
      sclk_n = 1'b1;
    end else if (tick) begin
      cnt_n  = '0;
      sclk_n = ~sclk_q;
    end else begin
      cnt_n  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      sclk_q     <= 1'b1;
      ext_prev_q <= 1'b1;
    end else begin
      cnt_q      <= cnt_n;
      sclk_q     <= sclk_n;
      ext_prev_q <= ext_sclk_s;
    end
  end

  // Edge strobes mark the cycle at whose end the shift clock changes level
  always_comb begin
    if (master) begin
      fall_ev = tick && sclk_q;
      rise_ev = tick && !sclk_q;
    end else begin
      fall_ev = ext_prev_q && !ext_sclk_s;
      rise_ev = !ext_prev_q && ext_sclk_s;
    end
  end

  assign sclk_out = sclk_q;

  // R2: generated clock returns high whenever it is not running
  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || !master) |=> sclk_q);

endmodule

// File: rtl/ssi_engine.sv
module ssi_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_ev,
  input  logic              rise_ev,
  input  logic              sample_fall,
  input  logic              sdi_bit,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              trig,
  output logic              busy,
  output logic [DATA_W-1:0] shreg,
  output logic              sdo,
  output logic              done
);

  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic              busy_q, busy_n;
  logic              armed_q, armed_n;
  logic [BIT_W-1:0]  bit_q, bit_n;
  logic [DATA_W-1:0] sr_q, sr_n;
  logic              sdo_q, sdo_n;
  logic              shift_ev;
  logic              accept;

  assign accept   = trig && armed_q && !busy_q;
  assign shift_ev = sample_fall ? fall_ev : rise_ev;

  always_comb begin
    busy_n  = busy_q;
    armed_n = armed_q;
    bit_n   = bit_q;
    sr_n    = sr_q;
    sdo_n   = sdo_q;
    done    = 1'b0;
    if (!busy_q) begin
      if (data_wr) begin
        sr_n = wdata;
      end
      if (data_wr || data_rd) begin
        armed_n = 1'b1;
      end
      if (accept) begin
        busy_n  = 1'b1;
        armed_n = 1'b0;
        bit_n   = '0;
      end
    end else begin
      if (fall_ev) begin
        sdo_n = sr_q[0];
      end
      if (shift_ev) begin
        sr_n = {sdi_bit, sr_q[DATA_W-1:1]};
      end
      if (rise_ev) begin
        if (bit_q == LAST_BIT) begin
          busy_n = 1'b0;
          done   = 1'b1;
        end else begin
          bit_n = bit_q + BIT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      armed_q <= 1'b0;
      bit_q   <= '0;
      sr_q    <= '0;
      sdo_q   <= 1'b1;
    end else begin
      busy_q  <= busy_n;
      armed_q <= armed_n;
      bit_q   <= bit_n;
      sr_q    <= sr_n;
      sdo_q   <= sdo_n;
    end
  end

  assign busy  = busy_q;
  assign shreg = sr_q;
  assign sdo   = sdo_q;

  // R3: output moves only after a falling shift edge of a running transfer
  a_r3_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_q) |-> $past(busy_q && fall_ev));

  // R6: without arming the engine cannot leave idle
  a_r6_no_start_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !busy_q) |=> !busy_q);

  // R7: a trigger during a transfer neither stops nor restarts it
  a_r7_trig_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && trig && !done) |=> busy_q);

  // R8: every start consumes the arming
  a_r8_start_consumes_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> ($past(armed_q) && !armed_q));

endmodule

// File: rtl/sync_shift_if.sv
module sync_shift_if
  import ssi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sclk_in,
  input  logic              sdi,
  output logic              sclk_out,
  output logic              sdo,
  output logic              irq
);

  logic rst_i;
  ssi_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (1'b1),
    .q    (rst_i)
  );

  logic [1:0] pins_s;
  ssi_sync #(.WIDTH(2), .STAGES(2), .RST_VAL(2'b10)) u_pin_sync (
    .clk  (clk),
    .rst_n(rst_i),
    .d    ({sclk_in, sdi}),
    .q    (pins_s)
  );

  // Register strobes
  logic wr_data, rd_data, wr_ctrl, wr_irq;
  assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
  assign rd_data = reg_rd && (reg_addr == ADDR_DATA);
  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_irq  = reg_wr && (reg_addr == ADDR_IRQ);

  logic     unused_wdata_hi;
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CTRL_TRIG+1];

  // Control and interrupt state
  clk_src_e src_q, src_n;
  logic     smp_fall_q, smp_fall_n;
  logic     mask_q, mask_n;
  logic     flag_q, flag_n;
  logic     trig;
  logic     done;
  logic     busy;
  logic     master;
  logic     fall_ev, rise_ev;
  logic     sdi_bit;
  logic [DATA_W-1:0] shreg;

  assign trig = wr_ctrl && reg_wdata[CTRL_TRIG];

  always_comb begin
    src_n      = src_q;
    smp_fall_n = smp_fall_q;
    mask_n     = mask_q;
    flag_n     = flag_q;
    if (wr_ctrl) begin
      src_n      = clk_src_e'(reg_wdata[1:0]);
      smp_fall_n = reg_wdata[CTRL_SAMPLE_FALL];
    end
    if (wr_irq) begin
      mask_n = reg_wdata[IRQ_MASK_BIT];
      if (reg_wdata[IRQ_FLAG_BIT]) begin
        flag_n = 1'b0;
      end
    end
    if (done) begin
      flag_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      src_q      <= CS_EXT;
      smp_fall_q <= 1'b0;
      mask_q     <= 1'b0;
      flag_q     <= 1'b0;
    end else begin
      src_q      <= src_n;
      smp_fall_q <= smp_fall_n;
      mask_q     <= mask_n;
      flag_q     <= flag_n;
    end
  end

  ssi_clkgen u_clkgen (
    .clk       (clk),
    .rst_n     (rst_i),
    .src       (src_q),
    .run       (busy),
    .ext_sclk_s(pins_s[1]),
    .master    (master),
    .sclk_out  (sclk_out),
    .fall_ev   (fall_ev),
    .rise_ev   (rise_ev)
  );

  // Own clock times the data in master mode; the peer's clock needs the synchronized copy
  assign sdi_bit = master ? sdi : pins_s[0];

  ssi_engine #(.DATA_W(DATA_W)) u_engine (
    .clk        (clk),
    .rst_n      (rst_i),
    .fall_ev    (fall_ev),
    .rise_ev    (rise_ev),
    .sample_fall(smp_fall_q),
    .sdi_bit    (sdi_bit),
    .data_wr    (wr_data),
    .data_rd    (rd_data),
    .wdata      (reg_wdata),
    .trig       (trig),
    .busy       (busy),
    .shreg      (shreg),
    .sdo        (sdo),
    .done       (done)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_DATA: reg_rdata = shreg;
      ADDR_CTRL: begin
        reg_rdata[1:0]              = src_q;
        reg_rdata[CTRL_SAMPLE_FALL] = smp_fall_q;
      end
      ADDR_IRQ: begin
        reg_rdata[IRQ_MASK_BIT] = mask_q;
        reg_rdata[IRQ_FLAG_BIT] = flag_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign irq = flag_q && mask_q;

  // R9: completion always leaves the flag set
  a_r9_flag_on_done: assert property (@(posedge clk) disable iff (!rst_i)
    done |=> flag_q);

endmodule

// File: tb/tb_sync_shift_if.sv
module tb_sync_shift_if;

  logic       clk;
  logic       rst_n;
  logic [1:0] reg_addr;
  logic       reg_wr;
  logic       reg_rd;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       sclk_in;
  logic       sdi;
  logic       sclk_out;
  logic       sdo;
  logic       irq;

  int checks;
  int errors;
  int cyc;
  logic mask_on;

  localparam int WATCHDOG = 150000;
  localparam int SLV_HALF = 6;

  // {select[1:0], sample_fall, tx[7:0], rx[7:0]}
  localparam int NVEC = 6;
  localparam logic [18:0] VEC [NVEC] = '{
    {2'b11, 1'b0, 8'hA5, 8'h3C},
    {2'b11, 1'b1, 8'h81, 8'h7E},
    {2'b10, 1'b0, 8'h12, 8'hE9},
    {2'b01, 1'b1, 8'hF0, 8'h0D},
    {2'b00, 1'b0, 8'h6B, 8'hC4},
    {2'b00, 1'b1, 8'h01, 8'hB7}
  };

  sync_shift_if dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .sclk_in  (sclk_in),
    .sdi      (sdi),
    .sclk_out (sclk_out),
    .sdo      (sdo),
    .irq      (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors + 1);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    reg_rd   = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd   = 1'b0;
  endtask

  task automatic wait_flag(output logic got);
    logic [7:0] v;
    got = 1'b0;
    for (int i = 0; i < 3000 && !got; i++) begin
      rd(2'd2, v);
      got = v[1];
    end
  endtask

  // Falling edges of sclk_out seen over n cycles
  task automatic count_falls(input int n, output int falls);
    logic prev;
    falls = 0;
    prev  = sclk_out;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (prev && !sclk_out) falls++;
      prev = sclk_out;
    end
  endtask

  function automatic int half_of(input logic [1:0] sel);
    case (sel)
      2'b11:   return 1;
      2'b10:   return 2;
      default: return 4;
    endcase
  endfunction

  task automatic peer_master(input logic edg, input logic [7:0] rx, input int half,
                             output logic [7:0] txc, output int pulses,
                             output int badlen, output int sdobad);
    logic prev, sprev, cur;
    int len, b, guard;
    prev = 1'b1; sprev = sdo; len = 0; b = 0; guard = 0;
    txc = '0; pulses = 0; badlen = 0; sdobad = 0;
    while (b < 8 && guard < 4000) begin
      @(negedge clk);
      guard++;
      cur = sclk_out;
      if (sdo !== sprev && !(prev && !cur)) sdobad++;
      sprev = sdo;
      if (cur != prev) begin
        if (!cur) begin
          pulses++;
          len = 1;
          if (!edg) sdi = rx[b];
        end else begin
          if (len != half) badlen++;
          txc[b] = sdo;
          if (edg && b < 7) sdi = rx[b+1];
          b++;
        end
      end else if (!cur) begin
        len++;
      end
      prev = cur;
    end
  endtask

  task automatic peer_slave(input logic edg, input logic [7:0] rx, output logic [7:0] txc);
    txc = '0;
    repeat (4) @(negedge clk);
    for (int b = 0; b < 8; b++) begin
      sclk_in = 1'b0;
      if (!edg) sdi = rx[b];
      repeat (SLV_HALF) @(negedge clk);
      txc[b]  = sdo;
      sclk_in = 1'b1;
      if (edg && b < 7) sdi = rx[b+1];
      repeat (SLV_HALF) @(negedge clk);
    end
  endtask

  task automatic do_xfer(input logic [1:0] sel, input logic edg, input logic [7:0] tx,
                         input logic [7:0] rx, input logic meddle);
    logic [7:0] txc, v;
    logic got;
    int pulses, badlen, sdobad, extra;
    pulses = 0; badlen = 0; sdobad = 0;
    sdi = edg ? rx[0] : 1'b0;
    wr(2'd1, {5'b0, edg, sel});
    wr(2'd0, tx);
    fork
      begin
        wr(2'd1, {4'b0, 1'b1, edg, sel});
        if (meddle) begin
          repeat (10) @(negedge clk);
          wr(2'd0, 8'hFF);
          wr(2'd1, {4'b0, 1'b1, edg, sel});
        end
      end
      begin
        if (sel == 2'b00) peer_slave(edg, rx, txc);
        else peer_master(edg, rx, half_of(sel), txc, pulses, badlen, sdobad);
      end
    join
    wait_flag(got);
    check("R9 flag set at completion", int'(got), 1);
    check("R9 irq equals flag and mask", int'(irq), int'(mask_on));
    check("R3 transmitted byte lsb first", int'(txc), int'(tx));
    if (sel != 2'b00) begin
      count_falls(20, extra);
      check("R2 exactly eight clock pulses", pulses + extra, 8);
      check("R2 low phase length from select", badlen, 0);
      check("R3 sdo changes only at falling edge", sdobad, 0);
      check("R2 clock idles high", int'(sclk_out), 1);
    end
    rd(2'd0, v);
    if (meddle) check("R7 received byte unaffected by writes while busy", int'(v), int'(rx));
    else if (edg) check("R4 falling-edge sampling result", int'(v), int'(rx));
    else check("R4 rising-edge sampling result", int'(v), int'(rx));
    wr(2'd2, {6'b0, 1'b1, mask_on});
    rd(2'd2, v);
    check("R9 write one clears flag", int'(v[1]), 0);
  endtask

  initial begin
    logic [7:0] v;
    logic got;
    int falls;
    checks = 0; errors = 0; cyc = 0; mask_on = 1'b0;
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    sclk_in = 1'b1; sdi = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd1, v);
    check("R1 control reset value", int'(v), 8'h00);
    rd(2'd2, v);
    check("R1 interrupt register reset value", int'(v), 8'h00);
    check("R1 irq low", int'(irq), 0);
    check("R1 sclk_out high", int'(sclk_out), 1);
    check("R1 sdo high", int'(sdo), 1);

    // R6 trigger without arming, and trigger readback
    wr(2'd1, 8'h0B);
    count_falls(40, falls);
    check("R6 unarmed trigger gives no pulses", falls, 0);
    rd(2'd1, v);
    check("R6 trigger reads back zero", int'(v), 8'h03);
    rd(2'd2, v);
    check("R6 unarmed trigger sets no flag", int'(v[1]), 0);

    // Vector table: main function over modes and edges
    for (int i = 0; i < NVEC; i++) begin
      do_xfer(VEC[i][18:17], VEC[i][16], VEC[i][15:8], VEC[i][7:0], 1'b0);
    end

    // R7 writes and triggers during a running transfer
    do_xfer(2'b01, 1'b0, 8'hC3, 8'h5A, 1'b1);

    // R8 second trigger without access, then read-arming
    sdi = 1'b1;
    wr(2'd1, 8'h03);
    wr(2'd0, 8'h5A);
    wr(2'd1, 8'h0B);
    wait_flag(got);
    check("R8 armed transfer completes", int'(got), 1);
    wr(2'd2, 8'h02);
    wr(2'd1, 8'h0B);
    count_falls(40, falls);
    check("R8 second trigger without access ignored", falls, 0);
    rd(2'd0, v);
    check("R8 data register holds received ones", int'(v), 8'hFF);
    sdi = 1'b0;
    fork
      wr(2'd1, 8'h0B);
      count_falls(40, falls);
    join
    check("R8 read arms the engine", falls, 8);
    rd(2'd0, v);
    check("R8 byte received after read-arming", int'(v), 8'h00);
    wr(2'd2, 8'h02);

    // R5 slave clock edges before trigger are ignored
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h11);
    sdi = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); sclk_in = 1'b0;
      repeat (SLV_HALF) @(negedge clk);
      sclk_in = 1'b1;
      repeat (SLV_HALF) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    rd(2'd2, v);
    check("R5 no completion without trigger", int'(v[1]), 0);
    rd(2'd0, v);
    check("R5 data unchanged by early edges", int'(v), 8'h11);

    // R9 mask gating
    wr(2'd2, 8'h01);
    mask_on = 1'b1;
    check("R9 irq low while flag clear", int'(irq), 0);
    do_xfer(2'b11, 1'b0, 8'h96, 8'h2D, 1'b0);
    check("R9 irq low after clear with mask set", int'(irq), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule